// File: doc/BRIEF.md
# Aliasing chip-select decoder

This block sits between a 32-bit processor bus and three memories: a 64 MB RAM at the bottom of the map, a boot ROM window and a main flash window. For each accepted request it drives one chip select and the address the device should see. Both ROM windows fill a 128 MB decode region that is larger than the device behind it. The address is folded into the device by masking, so the device image repeats across the whole region. Addresses that belong to no region, and writes to the boot window, get a one-cycle error response instead of a chip select.

The flash size (8, 16 or 32 MB) and a high-vectors strap are captured while reset is held. The strap sets the processor's reset fetch address and the vector-base control bit. The block also reports the physical flash location that this fetch address folds to. That location sits near the end of the physical flash because of the aliasing.

The bus side is a three-state machine. ST_IDLE accepts a request. ST_ACK is the one-cycle good response. ST_FAULT is the one-cycle error response. The transitions are:
- ST_IDLE to ST_ACK on a mapped request;
- ST_IDLE to ST_FAULT on an unmapped request or a boot-window write;
- ST_ACK to ST_IDLE and ST_FAULT to ST_IDLE always;
- ST_IDLE stays in ST_IDLE when there is no request.

Top module: `csd_alias_decoder`

## Requirements
- R1: An address below 0x04000000 selects RAM: `ram_cs` is high and `local_addr` equals the bus address.
- R2: A read whose address ANDed with 0xF8000000 equals 0xF0000000 selects the boot ROM: `boot_cs` is high and `local_addr` = 0xF0000000 OR (address AND 0x007FFFFF), the boot ROM being 8 MB.
- R3: An address whose address ANDed with 0xF8000000 equals 0xF8000000 selects flash: `flash_cs` is high and `local_addr` = 0xF8000000 OR (address AND (flash size − 1)). Every alias of a location gives the same `local_addr`.
- R4: The size code `size_sel` maps to flash sizes as follows: 0 gives 8 MB, 1 gives 16 MB, and 2 or 3 give 32 MB.
- R5: Any address outside RAM and both ROM regions asserts no chip select and gives `rsp_error` high with `local_addr` zero.
- R6: A write to RAM or flash raises `dev_we` together with that chip select. A read leaves `dev_we` low.
- R7: A write to the boot ROM window asserts no chip select and gives `rsp_error`.
- R8: All outputs are registered. `rsp_ready` is high for exactly one cycle, starting one cycle after a request is accepted in idle. At most one chip select is high, and chip selects appear only in a good response cycle.
- R9: With the strap high, `reset_vector` = 0xFFFF0000, `vec_high` = 1, and `reset_fetch_phys` is 0xF87F0000, 0xF8FF0000 or 0xF9FF0000 for 8, 16 or 32 MB. With the strap low, `reset_vector` = 0, `vec_high` = 0 and `reset_fetch_phys` = 0.
- R10: `size_sel` and `hivec_strap` are captured only while `rst_n` is low. Changing them after reset alters neither the fold nor the vector outputs.
- R11: While reset is held, every chip select, `dev_we`, `rsp_ready`, `rsp_error` and `local_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration capture window |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Bus address |
| size_sel | input | 2 | Flash size code, sampled in reset |
| hivec_strap | input | 1 | High-vectors strap, sampled in reset |
| ram_cs | output | 1 | RAM chip select |
| boot_cs | output | 1 | Boot ROM chip select |
| flash_cs | output | 1 | Main flash chip select |
| dev_we | output | 1 | Write enable to the selected device |
| local_addr | output | 32 | Folded device address |
| rsp_ready | output | 1 | Response valid, one cycle |
| rsp_error | output | 1 | Response is an error |
| reset_vector | output | 32 | Processor reset fetch address |
| reset_fetch_phys | output | 32 | Physical location the reset fetch folds to |
| vec_high | output | 1 | Vector-base control bit (bit 13 of the control register) |

## Verification
A request driven before a rising edge in idle shows its chip select, write enable, folded address and response on the outputs right after that edge. These outputs clear after the following edge. The bench therefore drives on a falling edge, samples the response at the next falling edge, and checks the idle state one falling edge later. The configuration outputs are due after the first rising edge with reset low, and they are checked only after reset is released and again after the strap and size inputs have been changed.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_RAM   = 2'd1,
        RGN_BOOT  = 2'd2,
        RGN_FLASH = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_FAULT = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic flash;
        logic boot;
        logic ram;
    } cs_t;
endpackage

// File: rtl/csd_cfg_latch.sv
module csd_cfg_latch
    import csd_pkg::*;
#(
    parameter int    FLASH_MIN_LOG2 = 23,
    parameter int    SIZE_CODES     = 3,
    parameter addr_t HIVEC_ADDR     = 32'hFFFF0000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] size_code,
    input  logic       hivec_strap,
    output addr_t      flash_mask,
    output addr_t      vec_addr,
    output logic       vec_high
);
    localparam int NCODES = 4;

    logic [1:0] code_q;
    logic       strap_q;
    addr_t      mask_tbl [NCODES];

    // Configuration is captured on every edge while reset is held, then frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= size_code;
            strap_q <= hivec_strap;
        end
    end

    // One mask per size code; codes past the last size reuse the largest.
    for (genvar g = 0; g < NCODES; g++) begin : g_mask
        localparam int LG = FLASH_MIN_LOG2 + ((g < SIZE_CODES) ? g : SIZE_CODES - 1);
        assign mask_tbl[g] = addr_t'((64'd1 << LG) - 64'd1);
    end

    assign flash_mask = mask_tbl[code_q];
    assign vec_addr   = strap_q ? HIVEC_ADDR : '0;
    assign vec_high   = strap_q;
endmodule

// File: rtl/csd_region_decode.sv
module csd_region_decode
    import csd_pkg::*;
#(
    parameter int    RAM_LOG2   = 26,
    parameter int    BOOT_LOG2  = 23,
    parameter addr_t WIN_MASK   = 32'hF8000000,
    parameter addr_t BOOT_BASE  = 32'hF0000000,
    parameter addr_t FLASH_BASE = 32'hF8000000
) (
    input  addr_t   addr,
    input  addr_t   flash_mask,
    output region_e region,
    output addr_t   phys
);
    localparam addr_t BOOT_MASK = addr_t'((64'd1 << BOOT_LOG2) - 64'd1);

    logic in_flash;
    logic in_boot;
    logic in_ram;

    assign in_flash = (addr & WIN_MASK) == FLASH_BASE;
    assign in_boot  = (addr & WIN_MASK) == BOOT_BASE;
    assign in_ram   = addr[ADDR_W-1:RAM_LOG2] == '0;

    // No range check inside a window: the low bits are masked, so images repeat.
    always_comb begin
        region = RGN_NONE;
        phys   = '0;
        if (in_flash) begin
            region = RGN_FLASH;
            phys   = FLASH_BASE | (addr & flash_mask);
        end else if (in_boot) begin
            region = RGN_BOOT;
            phys   = BOOT_BASE | (addr & BOOT_MASK);
        end else if (in_ram) begin
            region = RGN_RAM;
            phys   = addr;
        end
    end
endmodule

// File: rtl/csd_bus_fsm.sv
module csd_bus_fsm
    import csd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    req_write,
    input  region_e region,
    input  addr_t   phys,
    output cs_t     cs,
    output logic    dev_we,
    output addr_t   local_addr,
    output logic    rsp_ready,
    output logic    rsp_error
);
    bus_state_e state_q;
    bus_state_e state_d;
    logic       accept;
    logic       refused;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign refused = (region == RGN_NONE) || (req_write && region == RGN_BOOT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = refused ? ST_FAULT : ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Device-side outputs are loaded only for a good response and cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs         <= '0;
            dev_we     <= 1'b0;
            local_addr <= '0;
        end else if (accept && !refused) begin
            cs.ram     <= region == RGN_RAM;
            cs.boot    <= region == RGN_BOOT;
            cs.flash   <= region == RGN_FLASH;
            dev_we     <= req_write;
            local_addr <= phys;
        end else begin
            cs         <= '0;
            dev_we     <= 1'b0;
            local_addr <= '0;
        end
    end

    assign rsp_ready = state_q != ST_IDLE;
    assign rsp_error = state_q == ST_FAULT;
endmodule

// File: rtl/csd_alias_decoder.sv
module csd_alias_decoder
    import csd_pkg::*;
#(
    parameter int RAM_LOG2       = 26,
    parameter int BOOT_LOG2      = 23,
    parameter int FLASH_MIN_LOG2 = 23,
    parameter int SIZE_CODES     = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [1:0]  size_sel,
    input  logic        hivec_strap,
    output logic        ram_cs,
    output logic        boot_cs,
    output logic        flash_cs,
    output logic        dev_we,
    output logic [31:0] local_addr,
    output logic        rsp_ready,
    output logic        rsp_error,
    output logic [31:0] reset_vector,
    output logic [31:0] reset_fetch_phys,
    output logic        vec_high
);
    addr_t   flash_mask;
    addr_t   vec_addr;
    region_e bus_rgn;
    addr_t   bus_phys;
    region_e vec_rgn;
    addr_t   vec_phys;
    cs_t     cs;

    csd_cfg_latch #(
        .FLASH_MIN_LOG2 (FLASH_MIN_LOG2),
        .SIZE_CODES     (SIZE_CODES)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .size_code   (size_sel),
        .hivec_strap (hivec_strap),
        .flash_mask  (flash_mask),
        .vec_addr    (vec_addr),
        .vec_high    (vec_high)
    );

    csd_region_decode #(
        .RAM_LOG2  (RAM_LOG2),
        .BOOT_LOG2 (BOOT_LOG2)
    ) u_bus_dec (
        .addr       (req_addr),
        .flash_mask (flash_mask),
        .region     (bus_rgn),
        .phys       (bus_phys)
    );

    // Same fold applied to the reset fetch address.
    csd_region_decode #(
        .RAM_LOG2  (RAM_LOG2),
        .BOOT_LOG2 (BOOT_LOG2)
    ) u_vec_dec (
        .addr       (vec_addr),
        .flash_mask (flash_mask),
        .region     (vec_rgn),
        .phys       (vec_phys)
    );

    csd_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .region     (bus_rgn),
        .phys       (bus_phys),
        .cs         (cs),
        .dev_we     (dev_we),
        .local_addr (local_addr),
        .rsp_ready  (rsp_ready),
        .rsp_error  (rsp_error)
    );

    assign ram_cs           = cs.ram;
    assign boot_cs          = cs.boot;
    assign flash_cs         = cs.flash;
    assign reset_vector     = vec_addr;
    assign reset_fetch_phys = (vec_rgn == RGN_NONE) ? '0 : vec_phys;
endmodule

// File: rtl/csd_checker.sv
module csd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        ram_cs,
    input logic        boot_cs,
    input logic        flash_cs,
    input logic        dev_we,
    input logic [31:0] local_addr,
    input logic        rsp_ready,
    input logic        rsp_error,
    input logic [31:0] reset_vector,
    input logic [31:0] reset_fetch_phys,
    input logic        vec_high
);
    assert_ram_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> local_addr[31:26] == 6'd0);

    assert_boot_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        boot_cs |-> (local_addr[31:27] == 5'b11110 && local_addr[26:23] == 4'd0 && !dev_we));

    assert_flash_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs |-> local_addr[31:27] == 5'b11111);

    assert_unmapped_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready && req_addr[31:28] != 4'hF && req_addr[31:26] != 6'd0)
        |=> (rsp_error && !ram_cs && !boot_cs && !flash_cs));

    assert_we_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> (ram_cs || flash_cs));

    assert_boot_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready && req_write && req_addr[31:27] == 5'b11110)
        |=> (rsp_error && !boot_cs));

    assert_onehot_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, boot_cs, flash_cs}));

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    assert_accept_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready) |=> rsp_ready);

    assert_cs_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs || boot_cs || flash_cs) |-> (rsp_ready && !rsp_error));

    assert_hivec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_high |-> (reset_vector == 32'hFFFF0000 && reset_fetch_phys[31:27] == 5'b11111
                      && reset_fetch_phys[15:0] == 16'd0));

    assert_lovec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_high |-> (reset_vector == 32'd0 && reset_fetch_phys == 32'd0));

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(reset_fetch_phys) && $stable(vec_high)));
endmodule

bind csd_alias_decoder csd_checker u_chk (.*);

// File: tb/sim_csd_alias_decoder.sv
`timescale 1ns/1ps
module sim_csd_alias_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  size_sel = 2'd0;
    logic        hivec_strap = 1'b0;
    logic        ram_cs, boot_cs, flash_cs, dev_we, rsp_ready, rsp_error, vec_high;
    logic [31:0] local_addr, reset_vector, reset_fetch_phys;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    csd_alias_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .size_sel(size_sel), .hivec_strap(hivec_strap),
        .ram_cs(ram_cs), .boot_cs(boot_cs), .flash_cs(flash_cs), .dev_we(dev_we),
        .local_addr(local_addr), .rsp_ready(rsp_ready), .rsp_error(rsp_error),
        .reset_vector(reset_vector), .reset_fetch_phys(reset_fetch_phys),
        .vec_high(vec_high)
    );

    // Entry: {write, addr, cs{flash,boot,ram}, we, err, local}; flash 8 MB.
    localparam int NV = 14;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0, 32'h00000000, 3'b001, 1'b0, 1'b0, 32'h00000000},  // R1
        {1'b1, 32'h03FFFFFC, 3'b001, 1'b1, 1'b0, 32'h03FFFFFC},  // R1 R6
        {1'b0, 32'h04000000, 3'b000, 1'b0, 1'b1, 32'h00000000},  // R5
        {1'b0, 32'hF8000000, 3'b100, 1'b0, 1'b0, 32'hF8000000},  // R3
        {1'b0, 32'hF8800000, 3'b100, 1'b0, 1'b0, 32'hF8000000},  // R3 alias
        {1'b0, 32'hF9000000, 3'b100, 1'b0, 1'b0, 32'hF8000000},  // R3 alias
        {1'b0, 32'hFFFF0000, 3'b100, 1'b0, 1'b0, 32'hF87F0000},  // R3
        {1'b1, 32'hF8123454, 3'b100, 1'b1, 1'b0, 32'hF8123454},  // R6
        {1'b1, 32'hFC000010, 3'b100, 1'b1, 1'b0, 32'hF8000010},  // R6 alias
        {1'b0, 32'hF0000100, 3'b010, 1'b0, 1'b0, 32'hF0000100},  // R2
        {1'b0, 32'hF7800004, 3'b010, 1'b0, 1'b0, 32'hF0000004},  // R2 alias
        {1'b1, 32'hF0000000, 3'b000, 1'b0, 1'b1, 32'h00000000},  // R7
        {1'b0, 32'h80000000, 3'b000, 1'b0, 1'b1, 32'h00000000},  // R5
        {1'b0, 32'hEFFFFFFC, 3'b000, 1'b0, 1'b1, 32'h00000000}   // R5
    };

    task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [36:0] observe();
        return {flash_cs, boot_cs, ram_cs, dev_we, rsp_error, local_addr};
    endfunction

    function automatic logic [36:0] model(input logic wr, input logic [31:0] a, input int lg);
        logic [31:0] fm;
        fm = (32'd1 << lg) - 32'd1;
        if (a[31:27] == 5'b11111) return {3'b100, wr, 1'b0, 32'hF8000000 | (a & fm)};
        if (a[31:27] == 5'b11110)
            return wr ? {3'b000, 1'b0, 1'b1, 32'h0} : {3'b010, 1'b0, 1'b0, 32'hF0000000 | (a & 32'h007FFFFF)};
        if (a < 32'h04000000) return {3'b001, wr, 1'b0, a};
        return {3'b000, 1'b0, 1'b1, 32'h0};
    endfunction

    // Drive on a falling edge, sample the response one cycle later, then idle.
    task automatic do_req(input string req, input logic wr, input logic [31:0] a,
                          input logic [36:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        check({req, " response"}, observe(), exp);
        check("R8 ready", {36'd0, rsp_ready}, 37'd1);
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);
        check("R8 idle after", {35'd0, rsp_ready, ram_cs | boot_cs | flash_cs}, 37'd0);
    endtask

    task automatic do_reset(input logic [1:0] sz, input logic strap);
        @(negedge clk);
        rst_n = 1'b0; size_sel = sz; hivec_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        size_sel = 2'd0; hivec_strap = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 reset outputs", {observe()[36:32], local_addr}, 37'd0);
        check("R11 reset ready", {36'd0, rsp_ready}, 37'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 with 8 MB
        check("R9 vector 8MB", {4'd0, vec_high, reset_vector}, {4'd0, 1'b1, 32'hFFFF0000});
        check("R9 fetch phys 8MB", {5'd0, reset_fetch_phys}, {5'd0, 32'hF87F0000});

        for (int i = 0; i < NV; i++) begin
            do_req($sformatf("R1-7 vector %0d", i), VEC[i][69], VEC[i][68:37], VEC[i][36:0]);
        end

        // R10: change configuration after reset, expect no effect
        size_sel = 2'd2; hivec_strap = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 vector kept", {4'd0, vec_high, reset_vector}, {4'd0, 1'b1, 32'hFFFF0000});
        check("R10 fetch phys kept", {5'd0, reset_fetch_phys}, {5'd0, 32'hF87F0000});
        do_req("R10 fold kept", 1'b0, 32'hF8800000, model(1'b0, 32'hF8800000, 23));

        // R4 16 MB, strap high
        do_reset(2'd1, 1'b1);
        check("R9 fetch phys 16MB", {5'd0, reset_fetch_phys}, {5'd0, 32'hF8FF0000});
        do_req("R4 16MB alias", 1'b0, 32'hF9000000, model(1'b0, 32'hF9000000, 24));
        do_req("R4 16MB inside", 1'b0, 32'hF8800000, model(1'b0, 32'hF8800000, 24));

        // R4 32 MB, strap low
        do_reset(2'd2, 1'b0);
        check("R9 low vector", {4'd0, vec_high, reset_vector}, 37'd0);
        check("R9 low fetch phys", {5'd0, reset_fetch_phys}, 37'd0);
        do_req("R4 32MB alias", 1'b0, 32'hFA000004, model(1'b0, 32'hFA000004, 25));
        do_req("R4 32MB inside", 1'b1, 32'hF9000000, model(1'b1, 32'hF9000000, 25));

        // R4 code 3 behaves as 32 MB
        do_reset(2'd3, 1'b1);
        check("R9 fetch phys code3", {5'd0, reset_fetch_phys}, {5'd0, 32'hF9FF0000});
        do_req("R4 code3 fold", 1'b0, 32'hFBFFFFFC, model(1'b0, 32'hFBFFFFFC, 25));
        do_req("R7 boot write", 1'b1, 32'hF4000000, model(1'b1, 32'hF4000000, 25));
        do_req("R2 boot top", 1'b0, 32'hF7FFFFFC, model(1'b0, 32'hF7FFFFFC, 25));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule